// File: doc/BRIEF.md
# Indexed Attribute-Table RAM Controller

This block owns an 8 KiB work RAM and makes it visible to a host processor through a 24-bit address, 8-bit data bus. Most of the decoded window behaves as plain RAM. A handful of control offsets at the top of the window hold a cursor made of three parts: a table index, a two-bit field position and a choice between two table base addresses. Through the cursor the host reaches four-byte entry records and two-bit attribute fields packed four to a byte.

When the host writes a packed field, the block reads the shared byte and then writes it back with only the selected two bits replaced. This takes two cycles, and `host_ready` stays low in between. After reset the block rebuilds the cursor from the bytes last stored at the two cursor-control offsets, and only then accepts host accesses. Addresses outside the window are never acknowledged, so another device on the bus can serve them.

Top module: `attr_table_ram_ctrl`

## Requirements
- R1: An address whose bank (bits 23:16) is 0x00–0x3F or 0x80–0xBF and whose in-bank address (bits 15:0) is 0x6000–0x7FFF is claimed and reaches RAM offset = address bits 12:0.
- R2: Banks 0x70, 0x71, 0xF0 and 0xF1 are also claimed when the in-bank address is 0x6000–0x7FFF or 0xE000–0xFFFF, again at offset = bits 12:0. Every other address gets no acknowledge, and a write to it changes no RAM byte.
- R3: A write to offset 0x1FF5 selects the table base. Data bit 0 = 1 gives base 0x1800, and bit 0 = 0 gives base 0x1C00. The byte is also stored at offset 0x1FF5.
- R4: A write to offset 0x1FF6 loads the index from data bits 6:0 and the field shift from data bits 1:0 times 2. The byte is also stored at offset 0x1FF6.
- R5: Offsets 0x1FF0+k, for k = 0..3, read and write RAM at base + index*4 + k.
- R6: A read of offset 0x1FF4 returns the whole byte at base + 0x200 + (index >> 2).
- R7: A write to offset 0x1FF4 replaces only bits [shift+1:shift] of that byte with data bits 1:0. For example, index 3 with shift 6 writing 3 into a zero byte leaves 0xC0. `host_ready` is low for the cycle after the request, and the acknowledge arrives two cycles after the request.
- R8: Every other offset in the window is a plain RAM read or write at that offset.
- R9: A claimed access is acknowledged one cycle after the request. For a read, `host_rdata` is valid in the cycle `host_ack` is high.
- R10: After reset, `host_ready` is low while the cursor is rebuilt: the base comes from bit 0 of RAM[0x1FF5], the index from RAM[0x1FF6] bits 6:0, and the shift from RAM[0x1FF6] bits 1:0 times 2. `host_ready` goes high within a few cycles.
- R11: A request made while `host_ready` is low is ignored: it gets no acknowledge and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the cursor rebuild |
| host_req | input | 1 | Access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 24 | Bank (23:16) and in-bank address (15:0) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid with host_ack |
| host_ack | output | 1 | Claimed access completed |
| host_ready | output | 1 | Block accepts a new request |

## Verification
The entry records are swept over both bases and a spread of indices, including 0, 127 and values whose low bits differ. Each written byte is read back at its computed flat offset, which separates a wrong index scale from a wrong base. The packed field is swept over sixteen indices per base, so all four shifts and several slot bytes occur. Each merge starts from a non-uniform prior byte, so damage to neighbouring fields shows up. The decoder is tried with aliases in every claimed bank group and with addresses just outside each range, and the rebuild is checked by storing cursor bytes, pulsing reset and reading through the cursor.

// File: rtl/attr_tbl_pkg.sv
package attr_tbl_pkg;

   typedef enum logic [2:0] {
      ST_LD_BASE,
      ST_LD_CUR,
      ST_LD_FIN,
      ST_IDLE,
      ST_MERGE
   } ctl_state_e;

   typedef enum logic [1:0] {
      K_PLAIN,
      K_ENTRY,
      K_PACKED
   } acc_kind_e;

   localparam int BYTE_W  = 8;
   localparam int FIELD_W = 2;
   localparam int SH_W    = 3;

   function automatic logic [BYTE_W-1:0] field_merge(
      input logic [BYTE_W-1:0]  old_b,
      input logic [FIELD_W-1:0] val,
      input logic [SH_W-1:0]    sh
   );
      logic [BYTE_W-1:0] m;
      m = BYTE_W'({FIELD_W{1'b1}}) << sh;
      return (old_b & ~m) | ((BYTE_W'(val) << sh) & m);
   endfunction

endpackage

// File: rtl/atr_win_decode.sv
module atr_win_decode #(
   parameter int ADDR_W = 24,
   parameter int OFS_W  = 13
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [OFS_W-1:0]  ofs
);
   localparam int BANK_W = ADDR_W - 16;

   logic [BANK_W-1:0] bank;
   logic [15:0]       inb;
   logic              main_bank, mirr_bank, low_win, high_win;

   always_comb begin
      bank      = addr[ADDR_W-1 -: BANK_W];
      inb       = addr[15:0];
      // bit 7 of the bank is ignored: 00-3F and 80-BF alias
      main_bank = (bank[6] == 1'b0);
      mirr_bank = (bank[6:1] == 6'b111000);
      low_win   = (inb[15:13] == 3'b011);
      high_win  = (inb[15:13] == 3'b111);
      hit       = (main_bank && low_win) || (mirr_bank && (low_win || high_win));
      ofs       = addr[OFS_W-1:0];
   end
endmodule

// File: rtl/atr_cursor.sv
module atr_cursor #(
   parameter int IDX_W   = 7,
   parameter int FIELD_W = 2,
   parameter int SH_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             base_ld,
   input  logic             base_bit,
   input  logic             idx_ld,
   input  logic [7:0]       cfg_byte,
   output logic             base_sel,
   output logic [IDX_W-1:0] idx,
   output logic [SH_W-1:0]  shift
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_sel <= 1'b0;
         idx      <= '0;
         shift    <= '0;
      end else begin
         if (base_ld) base_sel <= base_bit;
         if (idx_ld) begin
            idx   <= cfg_byte[IDX_W-1:0];
            shift <= SH_W'(32'(cfg_byte[FIELD_W-1:0]) * FIELD_W);
         end
      end
   end

   p_base_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      base_ld |=> (base_sel == $past(base_bit)));
   p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_ld |=> ($stable(idx) && $stable(shift)));
   p_shift_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
      idx_ld |=> (shift[0] == 1'b0 && shift[2:1] == $past(cfg_byte[1:0])));
endmodule

// File: rtl/atr_addr_gen.sv
module atr_addr_gen
   import attr_tbl_pkg::*;
#(
   parameter int OFS_W = 13,
   parameter int IDX_W = 7
) (
   input  logic [OFS_W-1:0] ofs,
   input  logic             base_sel,
   input  logic [IDX_W-1:0] idx,
   output logic [OFS_W-1:0] tgt,
   output acc_kind_e        kind
);
   localparam int SPAN      = 2 ** OFS_W;
   localparam int BASE_HI   = SPAN - SPAN / 8;
   localparam int BASE_LO   = SPAN - SPAN / 4;
   localparam int PACK_OFS  = SPAN / 16;
   localparam int REG_ENT0  = SPAN - 16;
   localparam int REG_PACK  = SPAN - 12;

   logic [OFS_W-1:0] base, ent_a, pk_a;

   always_comb begin
      base  = base_sel ? OFS_W'(BASE_LO) : OFS_W'(BASE_HI);
      ent_a = base + OFS_W'({idx, 2'b00}) + OFS_W'(ofs[1:0]);
      pk_a  = base + OFS_W'(PACK_OFS) + OFS_W'(idx >> 2);
      if (ofs[OFS_W-1:2] == REG_ENT0[OFS_W-1:2]) begin
         kind = K_ENTRY;
         tgt  = ent_a;
      end else if (ofs == OFS_W'(REG_PACK)) begin
         kind = K_PACKED;
         tgt  = pk_a;
      end else begin
         kind = K_PLAIN;
         tgt  = ofs;
      end
   end
endmodule

// File: rtl/atr_byte_ram.sv
module atr_byte_ram #(
   parameter int AW    = 13,
   parameter int LANES = 4
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   localparam int LANE_W = $clog2(LANES);
   localparam int DEPTH  = 2 ** (AW - LANE_W);

   logic [LANE_W-1:0]  lane;
   logic [AW-LANE_W-1:0] word;
   logic [LANE_W-1:0]  lane_r;
   logic [LANES*8-1:0] lane_bus;

   assign lane = addr[LANE_W-1:0];
   assign word = addr[AW-1:LANE_W];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] mem [DEPTH];
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (en) begin
            if (we && lane == LANE_W'(l)) mem[word] <= wdata;
            q <= mem[word];
         end
      end
      assign lane_bus[l*8 +: 8] = q;
   end

   always_ff @(posedge clk) begin
      if (en) lane_r <= lane;
   end

   assign rdata = lane_bus[lane_r*8 +: 8];
endmodule

// File: rtl/attr_table_ram_ctrl.sv
module attr_table_ram_ctrl
   import attr_tbl_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int OFS_W  = 13,
   parameter int IDX_W  = 7,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   output logic              host_ack,
   output logic              host_ready
);
   localparam int SPAN     = 2 ** OFS_W;
   localparam int REG_BSEL = SPAN - 11;
   localparam int REG_CUR  = SPAN - 10;

   if (ADDR_W != 24) begin : g_bad_aw
      $error("ADDR_W must be 24");
   end
   if ((2 ** IDX_W) * 4 > SPAN / 16) begin : g_bad_idx
      $error("entry table overlaps packed area");
   end
   if (OFS_W < 8 || (LANES & (LANES - 1)) != 0) begin : g_bad_ram
      $error("bad RAM geometry");
   end

   ctl_state_e       st;
   logic             hit, start;
   logic [OFS_W-1:0] ofs, tgt;
   acc_kind_e        kind;
   logic             base_sel, base_ld, base_bit, idx_ld;
   logic [7:0]       cfg_byte;
   logic [IDX_W-1:0] idx;
   logic [SH_W-1:0]  shift;
   logic             ram_en, ram_we;
   logic [OFS_W-1:0] ram_addr, mrg_addr;
   logic [7:0]       ram_wdata, ram_q;
   logic [1:0]       mrg_val;
   logic [SH_W-1:0]  mrg_shift;
   logic             ack_q;

   atr_win_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dec (
      .addr(host_addr), .hit(hit), .ofs(ofs)
   );

   atr_addr_gen #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_agen (
      .ofs(ofs), .base_sel(base_sel), .idx(idx), .tgt(tgt), .kind(kind)
   );

   atr_cursor #(.IDX_W(IDX_W), .FIELD_W(FIELD_W), .SH_W(SH_W)) u_cur (
      .clk(clk), .rst_n(rst_n), .base_ld(base_ld), .base_bit(base_bit),
      .idx_ld(idx_ld), .cfg_byte(cfg_byte), .base_sel(base_sel),
      .idx(idx), .shift(shift)
   );

   atr_byte_ram #(.AW(OFS_W), .LANES(LANES)) u_ram (
      .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
      .wdata(ram_wdata), .rdata(ram_q)
   );

   assign host_ready = (st == ST_IDLE);
   assign start      = host_req && hit && host_ready;
   assign host_ack   = ack_q;
   assign host_rdata = ram_q;

   always_comb begin
      ram_en    = 1'b0;
      ram_we    = 1'b0;
      ram_addr  = tgt;
      ram_wdata = host_wdata;
      base_ld   = 1'b0;
      base_bit  = host_wdata[0];
      idx_ld    = 1'b0;
      cfg_byte  = host_wdata;
      unique case (st)
         ST_LD_BASE: begin
            ram_en   = 1'b1;
            ram_addr = OFS_W'(REG_BSEL);
         end
         ST_LD_CUR: begin
            ram_en   = 1'b1;
            ram_addr = OFS_W'(REG_CUR);
            base_ld  = 1'b1;
            base_bit = ram_q[0];
         end
         ST_LD_FIN: begin
            idx_ld   = 1'b1;
            cfg_byte = ram_q;
         end
         ST_IDLE: begin
            if (start) begin
               ram_en  = 1'b1;
               ram_we  = host_we && (kind != K_PACKED);
               base_ld = host_we && (ofs == OFS_W'(REG_BSEL));
               idx_ld  = host_we && (ofs == OFS_W'(REG_CUR));
            end
         end
         ST_MERGE: begin
            ram_en    = 1'b1;
            ram_we    = 1'b1;
            ram_addr  = mrg_addr;
            ram_wdata = field_merge(ram_q, mrg_val, mrg_shift);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_LD_BASE;
         ack_q     <= 1'b0;
         mrg_addr  <= '0;
         mrg_val   <= '0;
         mrg_shift <= '0;
      end else begin
         ack_q <= 1'b0;
         unique case (st)
            ST_LD_BASE: st <= ST_LD_CUR;
            ST_LD_CUR:  st <= ST_LD_FIN;
            ST_LD_FIN:  st <= ST_IDLE;
            ST_IDLE: begin
               if (start) begin
                  if (host_we && kind == K_PACKED) begin
                     st        <= ST_MERGE;
                     mrg_addr  <= tgt;
                     mrg_val   <= host_wdata[1:0];
                     mrg_shift <= shift;
                  end else begin
                     ack_q <= 1'b1;
                  end
               end
            end
            ST_MERGE: begin
               st    <= ST_IDLE;
               ack_q <= 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   p_ack_claimed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |-> ($past(host_req && hit) || $past(st == ST_MERGE)));
   p_merge_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && host_we && kind == K_PACKED) |=> (!host_ready && !host_ack));
   p_merge_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MERGE) |=> (host_ack && host_ready));
   p_read_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !host_we) |=> host_ack);
   p_busy_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_ready && st != ST_MERGE) |=> !host_ack);
   p_reload_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LD_FIN) |=> host_ready);
endmodule

// File: tb/attr_table_ram_ctrl_tb.sv
module attr_table_ram_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic        host_we = 1'b0;
   logic [23:0] host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        host_ack;
   logic        host_ready;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   attr_table_ram_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_ack(host_ack), .host_ready(host_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] win(input int o);
      return 24'h006000 | 24'(o & 16'h1FFF);
   endfunction

   task automatic acc(input bit we, input logic [23:0] a, input logic [7:0] d,
                      output logic [7:0] rd, output int lat);
      while (!host_ready) @(negedge clk);
      host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_req = 1'b0;
      lat = 0; rd = 8'h00;
      for (int i = 1; i <= 4; i++) begin
         if (host_ack) begin lat = i; rd = host_rdata; break; end
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic [23:0] a, input logic [7:0] d);
      logic [7:0] r; int l;
      acc(1'b1, a, d, r, l);
   endtask

   task automatic rd(input logic [23:0] a, output logic [7:0] v);
      int l;
      acc(1'b0, a, 8'h00, v, l);
   endtask

   task automatic do_reset(output int cyc);
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         if (host_ready) begin cyc = i; break; end
      end
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v, e, p;
      int lat, cyc, ent, slot, sh;
      // reset state
      @(negedge clk);
      chk(host_ready == 1'b0 && host_ack == 1'b0, "R10 reset", {host_ready, host_ack}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(host_ready == 1'b0, "R10 ready low during rebuild", host_ready, 0);
      cyc = 0;
      for (int i = 0; i < 8 && !host_ready; i++) @(negedge clk);
      chk(host_ready == 1'b1, "R10 ready after rebuild", host_ready, 1);

      // R8 plain offsets and R9 latency
      foreach (p[i]) ;
      for (int o = 0; o < 8192; o += 1021) begin
         if (o >= 16'h1800) continue;
         wr(win(o), 8'(o * 7 + 3));
         acc(1'b0, win(o), 8'h00, v, lat);
         chk(v == 8'(o * 7 + 3), "R8 plain offset", v, 8'(o * 7 + 3));
         chk(lat == 1, "R9 read latency", lat, 1);
      end
      wr(win(16'h1FFF), 8'h3C); rd(win(16'h1FFF), v);
      chk(v == 8'h3C, "R8 top offset", v, 8'h3C);
      wr(win(16'h1FF7), 8'hD2); rd(win(16'h1FF7), v);
      chk(v == 8'hD2, "R8 offset 0x1FF7", v, 8'hD2);

      // R1 / R2 aliases
      wr(24'h006123, 8'h71);
      foreach (v[i]) ;
      rd(24'hBF6123, v); chk(v == 8'h71, "R1 bank BF alias", v, 8'h71);
      rd(24'h3F6123, v); chk(v == 8'h71, "R1 bank 3F alias", v, 8'h71);
      rd(24'h706123, v); chk(v == 8'h71, "R2 bank 70 low", v, 8'h71);
      rd(24'hF1E123, v); chk(v == 8'h71, "R2 bank F1 high", v, 8'h71);
      rd(24'h71E123, v); chk(v == 8'h71, "R2 bank 71 high", v, 8'h71);
      wr(24'hF07FFF, 8'h99); rd(24'h807FFF, v);
      chk(v == 8'h99, "R1 bank 80 top", v, 8'h99);
      // R2 unclaimed addresses
      begin
         logic [23:0] bad [8];
         bad = '{24'h406123, 24'h008123, 24'h005123, 24'h726123,
                 24'h708123, 24'h00E123, 24'hC06123, 24'hF2E123};
         foreach (bad[i]) begin
            acc(1'b1, bad[i], 8'h0F, v, lat);
            chk(lat == 0, "R2 unclaimed no ack", lat, 0);
         end
         rd(24'h006123, v);
         chk(v == 8'h71, "R2 unclaimed writes leave RAM", v, 8'h71);
      end

      // R3 R4 R5 entry sweep
      for (int b = 0; b < 2; b++) begin
         int ix [7] = '{0, 1, 2, 3, 5, 77, 127};
         wr(win(16'h1FF5), 8'(b | 8'h40));
         rd(win(16'h1FF5), v);
         chk(v == 8'(b | 8'h40), "R3 select byte stored", v, 8'(b | 8'h40));
         foreach (ix[j]) begin
            wr(win(16'h1FF6), 8'(ix[j] | 8'h80));
            rd(win(16'h1FF6), v);
            chk(v == 8'(ix[j] | 8'h80), "R4 cursor byte stored", v, 8'(ix[j] | 8'h80));
            for (int k = 0; k < 4; k++) begin
               e   = 8'((ix[j] * 4 + k) ^ (b * 8'h55) ^ 8'hA0);
               ent = (b ? 16'h1800 : 16'h1C00) + ix[j] * 4 + k;
               wr(win(16'h1FF0 + k), e);
               rd(win(ent), v);
               chk(v == e, "R5 entry at base+index*4+k (R3 base)", v, e);
               wr(win(ent), ~e);
               rd(win(16'h1FF0 + k), v);
               chk(v == ~e, "R5 entry read through cursor", v, ~e);
            end
         end
      end

      // R6 R7 packed sweep, all four shifts
      for (int b = 0; b < 2; b++) begin
         wr(win(16'h1FF5), 8'(b));
         for (int ix = 0; ix < 16; ix++) begin
            slot = (b ? 16'h1800 : 16'h1C00) + 16'h200 + (ix >> 2);
            sh   = (ix & 3) * 2;
            p    = 8'hA5 ^ 8'(ix * 17);
            wr(win(slot), p);
            wr(win(16'h1FF6), 8'(ix));
            rd(win(16'h1FF4), v);
            chk(v == p, "R6 packed slot read", v, p);
            acc(1'b1, win(16'h1FF4), 8'(ix ^ 8'hFE), v, lat);
            chk(lat == 2, "R7 merge ack latency", lat, 2);
            e = (p & ~(8'h03 << sh)) | (8'((ix ^ 2) & 3) << sh);
            rd(win(slot), v);
            chk(v == e, "R7 field merge", v, e);
         end
      end
      // R7 worked example
      wr(win(16'h1FF5), 8'h00);
      wr(win(16'h1E00), 8'h00);
      wr(win(16'h1FF6), 8'h03);
      wr(win(16'h1FF4), 8'h03);
      rd(win(16'h1E00), v);
      chk(v == 8'hC0, "R7 example", v, 8'hC0);

      // R11 request while busy is ignored
      wr(win(16'h0444), 8'h5E);
      while (!host_ready) @(negedge clk);
      host_req = 1'b1; host_we = 1'b1; host_addr = win(16'h1FF4); host_wdata = 8'h00;
      @(negedge clk);
      chk(host_ready == 1'b0, "R7 ready low during merge", host_ready, 0);
      host_addr = win(16'h0444); host_wdata = 8'h11;
      @(negedge clk);
      host_req = 1'b0;
      chk(host_ack == 1'b1, "R7 merge ack", host_ack, 1);
      @(negedge clk);
      chk(host_ack == 1'b0, "R11 busy request not acked", host_ack, 0);
      rd(win(16'h0444), v);
      chk(v == 8'h5E, "R11 busy request wrote nothing", v, 8'h5E);

      // R10 rebuild from stored cursor bytes
      wr(win(16'h1FF5), 8'h01);
      wr(win(16'h1FF6), 8'hCD);
      wr(win(16'h1800 + 77 * 4 + 2), 8'h5A);
      wr(win(16'h1800 + 16'h200 + 19), 8'h00);
      do_reset(cyc);
      chk(cyc >= 2 && cyc <= 5, "R10 rebuild length", cyc, 3);
      rd(win(16'h1FF2), v);
      chk(v == 8'h5A, "R10 rebuilt base and index", v, 8'h5A);
      wr(win(16'h1FF4), 8'h02);
      rd(win(16'h1800 + 16'h200 + 19), v);
      chk(v == 8'h08, "R10 rebuilt shift", v, 8'h08);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule